// File: doc/BRIEF.md
# DMA Global Control and Channel Gating

This block holds the global control and status word of an eight-channel DMA engine and decides, on every cycle, which channels are allowed to move data and which single requester is served next. The word carries a master enable, two sticky status flags (one set by a non-maskable interrupt pulse, one set by an address-error indication), a mode select between a standard layout and an alternate layout, and a width bit that matters only in the alternate layout.

Each channel contributes its own enable and transfer-end bits. The block combines these with the global word to produce one "transfer permitted" line per channel. It then filters the raw external, automatic and peripheral requests through the current layout and drives a one-hot grant to the permitted requester with the lowest channel number. The CPU reads and writes the word through a strobe-based port. The status flags can only be cleared by a write of 0 that comes after a read that returned 1.

Top module: `dma_gate_ctrl`

## Requirements
- R1: A high `nmi_in` at a rising clock edge sets the interrupt flag (read bit 1) after that edge, whatever the master enable or channel activity.
- R2: A write of 1 to a status flag has no effect. A write of 0 to a status flag that has not been read as 1 since it was last set also has no effect.
- R3: A write of 0 to the interrupt flag after a read that returned it as 1 clears it on that edge. If `nmi_in` is high on the same edge, the flag stays 1.
- R4: The address-error flag (read bit 2) follows the same set, ignore and clear rules through `aerr_in`. It keeps its own read history, separate from the interrupt flag.
- R5: `xfer_ok[i]` is 1 only when the master enable (bit 0) is 1, both flags are 0, `ch_de[i]` is 1, `ch_te[i]` is 0 and channel i exists in the current layout.
- R6: Clearing the master enable, or setting either flag, drops every `xfer_ok` line and every grant from the next cycle on.
- R7: In the standard layout (bit 3 = 0) all eight channels exist. External requests count only on channels 0 and 1. Automatic and peripheral requests count on every channel. Bit 4 has no effect in this layout.
- R8: In the alternate layout with bit 4 = 0, only channels 0 to 3 exist, and all four accept external requests.
- R9: In the alternate layout with bit 4 = 1, all eight channels exist and all accept external requests.
- R10: `grant` is one-hot or zero. It selects the lowest-numbered channel that is permitted and has a counted request.
- R11: After reset, every bit of the word reads 0 and no channel is permitted.
- R12: A new set event after a read of 1 cancels that read. The flag then needs a fresh read of 1 before a write of 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_rd | input | 1 | Read strobe for the control word |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 5 | Write data: bit0 enable, bit1 interrupt flag, bit2 address-error flag, bit3 alternate layout, bit4 wide |
| reg_rdata | output | 5 | Current control word, same bit layout |
| nmi_in | input | 1 | Interrupt event, sets the interrupt flag |
| aerr_in | input | 1 | Address-error event, sets the address-error flag |
| ch_de | input | 8 | Per-channel enable |
| ch_te | input | 8 | Per-channel transfer-end |
| ext_req | input | 8 | External request per channel |
| auto_req | input | 8 | Automatic request per channel |
| periph_req | input | 8 | On-chip peripheral request per channel |
| xfer_ok | output | 8 | Channel permitted to transfer |
| grant | output | 8 | One-hot grant to the served channel |

## Verification
The flag-clearing properties assume that a flag falls only when the cycle before carried a write strobe with a 0 in that bit and no set event. They also assume that `reg_wr` and the set inputs are sampled cleanly at the rising edge. The bench changes every input on the falling edge and pulses the set inputs for whole cycles, so each event lands on exactly one edge. Request and enable vectors are held steady while grants are sampled, so the one-hot and subset properties see settled values.

// File: rtl/dma_gate_pkg.sv
package dma_gate_pkg;

    localparam int REG_W = 5;

    // bit positions of the control word
    localparam int B_MEN  = 0;
    localparam int B_NMI  = 1;
    localparam int B_AERR = 2;
    localparam int B_ALT  = 3;
    localparam int B_WIDE = 4;

    typedef struct packed {
        logic men;
        logic alt;
        logic wide;
        logic nmi;
        logic aerr;
        logic nmi_arm;
        logic aerr_arm;
    } ctl_t;

    // returns {flag, armed} for a sticky flag cleared by write-0-after-read-1
    function automatic logic [1:0] flag_step(
        input logic flag,
        input logic armed,
        input logic set_ev,
        input logic rd,
        input logic wr,
        input logic wbit
    );
        logic f;
        logic a;
        f = flag;
        a = armed;
        if (set_ev) begin
            f = 1'b1;
            a = 1'b0;
        end else if (wr && !wbit && armed) begin
            f = 1'b0;
            a = 1'b0;
        end else if (rd && flag) begin
            a = 1'b1;
        end
        return {f, a};
    endfunction

endpackage

// File: rtl/dma_ctl_reg.sv
module dma_ctl_reg
    import dma_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             nmi_in,
    input  logic             aerr_in,
    output ctl_t             ctl
);

    ctl_t ctl_d, ctl_q;

    always_comb begin
        logic [1:0] nmi_step;
        logic [1:0] aerr_step;
        ctl_d = ctl_q;
        if (reg_wr) begin
            ctl_d.men  = reg_wdata[B_MEN];
            ctl_d.alt  = reg_wdata[B_ALT];
            ctl_d.wide = reg_wdata[B_WIDE];
        end
        nmi_step  = flag_step(ctl_q.nmi, ctl_q.nmi_arm, nmi_in,
                              reg_rd, reg_wr, reg_wdata[B_NMI]);
        aerr_step = flag_step(ctl_q.aerr, ctl_q.aerr_arm, aerr_in,
                              reg_rd, reg_wr, reg_wdata[B_AERR]);
        ctl_d.nmi      = nmi_step[1];
        ctl_d.nmi_arm  = nmi_step[0];
        ctl_d.aerr     = aerr_step[1];
        ctl_d.aerr_arm = aerr_step[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl = ctl_q;

endmodule

// File: rtl/dma_chan_gate.sv
module dma_chan_gate
    import dma_gate_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int NORM_EXT = 2,
    parameter int NARROW   = 4
) (
    input  ctl_t              ctl,
    input  logic [NUM_CH-1:0] ch_de,
    input  logic [NUM_CH-1:0] ch_te,
    input  logic [NUM_CH-1:0] ext_req,
    input  logic [NUM_CH-1:0] auto_req,
    input  logic [NUM_CH-1:0] periph_req,
    output logic [NUM_CH-1:0] permit,
    output logic [NUM_CH-1:0] req_eff
);

    logic global_ok;
    assign global_ok = ctl.men && !ctl.nmi && !ctl.aerr;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam bit IN_NARROW = (i < NARROW);
        localparam bit IN_NORM   = (i < NORM_EXT);
        logic exists;
        logic ext_ok;
        always_comb begin
            exists     = !ctl.alt || ctl.wide || IN_NARROW;
            ext_ok     = ctl.alt ? (ctl.wide || IN_NARROW) : IN_NORM;
            permit[i]  = global_ok && ch_de[i] && !ch_te[i] && exists;
            req_eff[i] = permit[i] &&
                         ((ext_req[i] && ext_ok) || auto_req[i] || periph_req[i]);
        end
    end

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH-1:0] req,
    output logic [NUM_CH-1:0] grant
);

    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_gate_ctrl.sv
module dma_gate_ctrl
    import dma_gate_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int NORM_EXT = 2,
    parameter int NARROW   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             nmi_in,
    input  logic             aerr_in,
    input  logic [NUM_CH-1:0] ch_de,
    input  logic [NUM_CH-1:0] ch_te,
    input  logic [NUM_CH-1:0] ext_req,
    input  logic [NUM_CH-1:0] auto_req,
    input  logic [NUM_CH-1:0] periph_req,
    output logic [NUM_CH-1:0] xfer_ok,
    output logic [NUM_CH-1:0] grant
);

    ctl_t              ctl;
    logic [NUM_CH-1:0] req_eff;

    dma_ctl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .nmi_in    (nmi_in),
        .aerr_in   (aerr_in),
        .ctl       (ctl)
    );

    dma_chan_gate #(
        .NUM_CH   (NUM_CH),
        .NORM_EXT (NORM_EXT),
        .NARROW   (NARROW)
    ) u_gate (
        .ctl        (ctl),
        .ch_de      (ch_de),
        .ch_te      (ch_te),
        .ext_req    (ext_req),
        .auto_req   (auto_req),
        .periph_req (periph_req),
        .permit     (xfer_ok),
        .req_eff    (req_eff)
    );

    dma_prio_arb #(.NUM_CH(NUM_CH)) u_arb (
        .req   (req_eff),
        .grant (grant)
    );

    always_comb begin
        reg_rdata         = '0;
        reg_rdata[B_MEN]  = ctl.men;
        reg_rdata[B_NMI]  = ctl.nmi;
        reg_rdata[B_AERR] = ctl.aerr;
        reg_rdata[B_ALT]  = ctl.alt;
        reg_rdata[B_WIDE] = ctl.wide;
    end

endmodule

// File: rtl/dma_gate_chk.sv
module dma_gate_chk
    import dma_gate_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int NARROW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              nmi_in,
    input logic              aerr_in,
    input logic [NUM_CH-1:0] ch_de,
    input logic [NUM_CH-1:0] ch_te,
    input logic [NUM_CH-1:0] xfer_ok,
    input logic [NUM_CH-1:0] grant
);

    assert_nmi_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_in |=> reg_rdata[B_NMI]);

    assert_aerr_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        aerr_in |=> reg_rdata[B_AERR]);

    assert_nmi_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_rdata[B_NMI]) |-> $past(reg_wr && !reg_wdata[B_NMI] && !nmi_in));

    assert_aerr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_rdata[B_AERR]) |-> $past(reg_wr && !reg_wdata[B_AERR] && !aerr_in));

    assert_permit_global_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|xfer_ok) |-> (reg_rdata[B_MEN] && !reg_rdata[B_NMI] && !reg_rdata[B_AERR]));

    assert_permit_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ok & ~(ch_de & ~ch_te)) == '0);

    assert_narrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[B_ALT] && !reg_rdata[B_WIDE]) |-> ((xfer_ok >> NARROW) == '0));

    assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_grant_permitted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~xfer_ok) == '0);

endmodule

bind dma_gate_ctrl dma_gate_chk #(.NUM_CH(NUM_CH), .NARROW(NARROW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .nmi_in    (nmi_in),
    .aerr_in   (aerr_in),
    .ch_de     (ch_de),
    .ch_te     (ch_te),
    .xfer_ok   (xfer_ok),
    .grant     (grant)
);

// File: tb/dma_gate_ctrl_test.sv
module dma_gate_ctrl_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_wdata = '0;
    logic [4:0] reg_rdata;
    logic       nmi_in = 1'b0;
    logic       aerr_in = 1'b0;
    logic [7:0] ch_de = '0;
    logic [7:0] ch_te = '0;
    logic [7:0] ext_req = '0;
    logic [7:0] auto_req = '0;
    logic [7:0] periph_req = '0;
    logic [7:0] xfer_ok;
    logic [7:0] grant;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dma_gate_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_rd     (reg_rd),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .nmi_in     (nmi_in),
        .aerr_in    (aerr_in),
        .ch_de      (ch_de),
        .ch_te      (ch_te),
        .ext_req    (ext_req),
        .auto_req   (auto_req),
        .periph_req (periph_req),
        .xfer_ok    (xfer_ok),
        .grant      (grant)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one write cycle; the word updates at the rising edge in between
    task automatic wr_word(input logic [4:0] v, input logic with_nmi = 1'b0);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v; nmi_in = with_nmi;
        @(negedge clk);
        reg_wr = 1'b0; nmi_in = 1'b0;
        #1;
    endtask

    task automatic rd_word();
        @(negedge clk);
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        #1;
    endtask

    task automatic pulse_nmi();
        @(negedge clk); nmi_in = 1'b1;
        @(negedge clk); nmi_in = 1'b0;
        #1;
    endtask

    task automatic pulse_aerr();
        @(negedge clk); aerr_in = 1'b1;
        @(negedge clk); aerr_in = 1'b0;
        #1;
    endtask

    task automatic set_req(input logic [7:0] e, input logic [7:0] a, input logic [7:0] p);
        @(negedge clk);
        ext_req = e; auto_req = a; periph_req = p;
        #1;
    endtask

    task automatic t_reset();
        check("R11", "word after reset", {3'b0, reg_rdata}, 8'h00);
        check("R11", "xfer_ok after reset", xfer_ok, 8'h00);
        check("R11", "grant after reset", grant, 8'h00);
    endtask

    task automatic t_permit();
        ch_de = 8'hFF; ch_te = 8'h00;
        wr_word(5'b00001);
        check("R5", "all permitted", xfer_ok, 8'hFF);
        @(negedge clk); ch_te = 8'h08; #1;
        check("R5", "te blocks ch3", xfer_ok, 8'hF7);
        @(negedge clk); ch_de = 8'hDF; #1;
        check("R5", "de=0 blocks ch5", xfer_ok, 8'hD7);
        @(negedge clk); ch_de = 8'hFF; ch_te = 8'h00; #1;
    endtask

    task automatic t_prio_normal();
        set_req(8'h00, 8'hA4, 8'h00);
        check("R10", "lowest auto wins", grant, 8'h04);
        set_req(8'hFF, 8'h00, 8'h00);
        check("R10", "ext ch0 wins", grant, 8'h01);
        set_req(8'hFC, 8'h00, 8'h00);
        check("R7", "ext on ch2..7 ignored", grant, 8'h00);
        set_req(8'hFC, 8'h00, 8'h80);
        check("R7", "periph on ch7 counts", grant, 8'h80);
        set_req(8'h00, 8'h00, 8'h00);
        wr_word(5'b10001);
        set_req(8'h04, 8'h00, 8'h00);
        check("R7", "wide bit ignored in standard layout", grant, 8'h00);
        check("R7", "standard layout all exist", xfer_ok, 8'hFF);
        set_req(8'h00, 8'h00, 8'h00);
        wr_word(5'b00001);
    endtask

    task automatic t_nmi();
        wr_word(5'b00000);
        pulse_nmi();
        check("R1", "nmi sets flag with enable off", {3'b0, reg_rdata}, 8'h02);
        wr_word(5'b00001);
        check("R2", "write 0 without read ignored", {3'b0, reg_rdata}, 8'h03);
        set_req(8'h00, 8'hFF, 8'h00);
        check("R6", "flag suspends all", xfer_ok, 8'h00);
        check("R6", "flag removes grant", grant, 8'h00);
        wr_word(5'b00011);
        check("R2", "write 1 ignored", {3'b0, reg_rdata}, 8'h03);
        rd_word();
        wr_word(5'b00011);
        check("R2", "write 1 after read ignored", {3'b0, reg_rdata}, 8'h03);
        wr_word(5'b00001);
        check("R3", "write 0 after read clears", {3'b0, reg_rdata}, 8'h01);
        check("R3", "channels resume", grant, 8'h01);
        // rearm rule
        pulse_nmi();
        rd_word();
        pulse_nmi();
        wr_word(5'b00001);
        check("R12", "new set cancels read", {3'b0, reg_rdata}, 8'h03);
        rd_word();
        wr_word(5'b00001, 1'b1);
        check("R3", "set beats clear in same cycle", {3'b0, reg_rdata}, 8'h03);
        rd_word();
        wr_word(5'b00001);
        check("R12", "fresh read then clear", {3'b0, reg_rdata}, 8'h01);
        set_req(8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_aerr();
        pulse_aerr();
        check("R4", "aerr sets flag", {3'b0, reg_rdata}, 8'h05);
        check("R6", "aerr suspends", xfer_ok, 8'h00);
        pulse_nmi();
        rd_word();
        wr_word(5'b00101);
        check("R4", "write 1 to aerr ignored, nmi cleared", {3'b0, reg_rdata}, 8'h05);
        wr_word(5'b00001);
        check("R4", "aerr clears after read", {3'b0, reg_rdata}, 8'h01);
        check("R4", "permits back", xfer_ok, 8'hFF);
    endtask

    task automatic t_men();
        set_req(8'h00, 8'h10, 8'h00);
        check("R10", "grant ch4", grant, 8'h10);
        wr_word(5'b00000);
        check("R6", "enable off suspends", xfer_ok, 8'h00);
        check("R6", "enable off no grant", grant, 8'h00);
        set_req(8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_modes();
        wr_word(5'b01001);
        check("R8", "narrow layout ch0..3", xfer_ok, 8'h0F);
        set_req(8'hF8, 8'h00, 8'h00);
        check("R8", "ext on ch3 accepted", grant, 8'h08);
        set_req(8'h00, 8'hF0, 8'h00);
        check("R8", "ch4..7 absent", grant, 8'h00);
        wr_word(5'b11001);
        check("R9", "wide layout all exist", xfer_ok, 8'hFF);
        set_req(8'h80, 8'h00, 8'h00);
        check("R9", "ext on ch7 accepted", grant, 8'h80);
        set_req(8'h00, 8'h00, 8'h00);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_permit();
        t_prio_normal();
        t_nmi();
        t_aerr();
        t_men();
        t_modes();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule